// File: doc/BRIEF.md
# Clock output gating and mode control

This block sits between a clock synthesizer and the output pads of a system clock generator. It takes clocks that have already been generated for the processor, PCI, interrupt-controller, reference and USB domains. It then applies the settings held in the control registers: a per-output run/stop bit, a 2-bit global operating mode, the source and value of the CPU frequency selection code handed back to the synthesizer, and the spread-spectrum settings. Every run/stop change is deferred until the affected clock is low, so a stopped or restarted output never shows a shortened pulse.

One output pin shares two drive stages, and each stage has its own enable bit. Both stages are driven from the AND of those two bits, so they cannot drive against each other. A strap input is sampled once after reset and decides whether the shared USB output carries the 48 MHz or the 24 MHz clock.

All clock inputs are treated as levels and sampled by the control clock `clk`, which must be fast relative to them. `rst_n` is asynchronous active-low and is released synchronously to `clk` by the surrounding logic.

Top module: `clkctl_top`

## Requirements
- R1: With a run bit at 1, its output follows its selected source clock. With the run bit at 0, the output is held low.
- R2: A new run bit value is taken into use only at a `clk` edge where the selected source of that output is low. Until then, the previous run state stays in force.
- R3: In mode 2'b00, the processor outputs carry `src_cpu`, the PCI outputs (free-running and gated) carry `src_pci`, `spread_on` is 0 and `pad_oe` is 1.
- R4: In mode 2'b01, the processor and PCI outputs carry `src_ref` in place of their own source, still subject to their run bits.
- R5: `spread_on` is 1 exactly when the mode is 2'b10. In that mode the outputs behave as in mode 2'b00.
- R6: In mode 2'b11, `pad_oe` is 0 and every clock output is low.
- R7: With `cfg_fsrc` at 0, `fsel_code` is 3'b011 when `hw_fast` is 1 (100 MHz) and 3'b001 when `hw_fast` is 0 (66.6 MHz).
- R8: With `cfg_fsrc` at 1, `fsel_code` equals `cfg_fcode`.
- R9: `spread_down` equals `cfg_spread_down` (0 = centre spread, 1 = down spread) in every mode.
- R10: `strap_sel48` is captured at the first `clk` edge after reset is released and held until the next reset. A captured 1 routes `src_48` to `mix_clk`, and a captured 0 routes `src_24`. Later changes of the strap pin have no effect.
- R11: `ref_clk_a` and `ref_clk_b` are always equal. Their run state is the AND of `cfg_en_ref[1]` and `cfg_en_ref[0]`.
- R12: During and straight after reset, every run state is 1, so every gated output follows its source. Until the strap is captured, `mix_clk` carries `src_48`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | control clock that samples sources and settings |
| rst_n | input | 1 | asynchronous active-low reset |
| strap_sel48 | input | 1 | strap: 1 = 48 MHz, 0 = 24 MHz on mix_clk |
| hw_fast | input | 1 | hardware frequency pin: 1 = 100 MHz, 0 = 66.6 MHz |
| cfg_mode | input | 2 | global mode: 00 run, 01 test, 10 spread, 11 outputs off |
| cfg_fsrc | input | 1 | frequency source: 0 pin, 1 register code |
| cfg_fcode | input | 3 | register frequency code |
| cfg_spread_down | input | 1 | spread shape: 0 centre, 1 down |
| cfg_en_cpu | input | NUM_CPU | run bits of processor outputs |
| cfg_en_pcif | input | 1 | run bit of free-running PCI output |
| cfg_en_pci | input | NUM_PCI | run bits of PCI outputs |
| cfg_en_apic | input | 1 | run bit of interrupt-controller output |
| cfg_en_ref | input | 2 | the two run bits of the shared reference pin |
| src_cpu | input | 1 | synthesized processor clock |
| src_pci | input | 1 | synthesized PCI clock |
| src_ref | input | 1 | reference clock |
| src_48 | input | 1 | 48 MHz clock |
| src_24 | input | 1 | 24 MHz clock |
| cpu_clk | output | NUM_CPU | processor clock outputs |
| pcif_clk | output | 1 | free-running PCI output |
| pci_clk | output | NUM_PCI | PCI clock outputs |
| apic_clk | output | 1 | interrupt-controller clock output |
| ref_clk_a | output | 1 | reference pin, first stage |
| ref_clk_b | output | 1 | reference pin, second stage |
| usb48_clk | output | 1 | fixed 48 MHz output |
| mix_clk | output | 1 | shared 48/24 MHz output |
| pad_oe | output | 1 | pad drive enable, 0 = outputs tristated |
| fsel_code | output | 3 | frequency code to the synthesizer |
| spread_on | output | 1 | spread modulation request |
| spread_down | output | 1 | spread shape to the synthesizer |

## Verification
The assertions assume that source clocks and control fields change away from the `clk` edge and stay put for the whole `clk` period. They also assume that `rst_n` is released between edges. The stimulus follows this: the bench changes every source and setting only at the falling edge of `clk`. The bench derives the sources from a cycle counter with different periods, so enable changes are requested while a source is high as well as while it is low. This exercises the deferred take-over.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  typedef enum logic [1:0] {
    MODE_RUN    = 2'b00,
    MODE_TEST   = 2'b01,
    MODE_SPREAD = 2'b10,
    MODE_HIZ    = 2'b11
  } run_mode_e;

  localparam int unsigned FCODE_W = 3;
  localparam logic [FCODE_W-1:0] FCODE_PIN_FAST = 3'b011;
  localparam logic [FCODE_W-1:0] FCODE_PIN_SLOW = 3'b001;
endpackage

// File: rtl/clkctl_gate_cell.sv
module clkctl_gate_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic en_req,
  output logic gclk,
  output logic en_state
);
  logic en_q;
  logic en_load;

  // a new run state is only accepted while the source is low
  always_comb begin
    en_load = ~src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b1;
    end else if (en_load) begin
      en_q <= en_req;
    end
  end

  assign gclk     = src & en_q;
  assign en_state = en_q;
endmodule

// File: rtl/clkctl_freq_sel.sv
module clkctl_freq_sel
  import clkctl_pkg::*;
(
  input  logic               hw_fast,
  input  logic               use_reg,
  input  logic [FCODE_W-1:0] reg_code,
  output logic [FCODE_W-1:0] code
);
  logic [FCODE_W-1:0] pin_code;

  always_comb begin
    pin_code = hw_fast ? FCODE_PIN_FAST : FCODE_PIN_SLOW;
    code     = use_reg ? reg_code : pin_code;
  end
endmodule

// File: rtl/clkctl_strap.sv
module clkctl_strap (
  input  logic clk,
  input  logic rst_n,
  input  logic strap,
  output logic sel48,
  output logic done
);
  logic sel_q, done_q;
  logic sel_d, done_d;
  logic cap_en;

  always_comb begin
    cap_en = ~done_q;
    sel_d  = strap;
    done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b1;
      done_q <= 1'b0;
    end else if (cap_en) begin
      sel_q  <= sel_d;
      done_q <= done_d;
    end
  end

  assign sel48 = sel_q;
  assign done  = done_q;
endmodule

// File: rtl/clkctl_top.sv
module clkctl_top
  import clkctl_pkg::*;
#(
  parameter int unsigned NUM_CPU = 2,
  parameter int unsigned NUM_PCI = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strap_sel48,
  input  logic               hw_fast,
  input  logic [1:0]         cfg_mode,
  input  logic               cfg_fsrc,
  input  logic [FCODE_W-1:0] cfg_fcode,
  input  logic               cfg_spread_down,
  input  logic [NUM_CPU-1:0] cfg_en_cpu,
  input  logic               cfg_en_pcif,
  input  logic [NUM_PCI-1:0] cfg_en_pci,
  input  logic               cfg_en_apic,
  input  logic [1:0]         cfg_en_ref,
  input  logic               src_cpu,
  input  logic               src_pci,
  input  logic               src_ref,
  input  logic               src_48,
  input  logic               src_24,
  output logic [NUM_CPU-1:0] cpu_clk,
  output logic               pcif_clk,
  output logic [NUM_PCI-1:0] pci_clk,
  output logic               apic_clk,
  output logic               ref_clk_a,
  output logic               ref_clk_b,
  output logic               usb48_clk,
  output logic               mix_clk,
  output logic               pad_oe,
  output logic [FCODE_W-1:0] fsel_code,
  output logic               spread_on,
  output logic               spread_down
);
  localparam int unsigned PCIF_IDX  = NUM_CPU;
  localparam int unsigned PCI_BASE  = NUM_CPU + 1;
  localparam int unsigned APIC_IDX  = PCI_BASE + NUM_PCI;
  localparam int unsigned REF_IDX   = APIC_IDX + 1;
  localparam int unsigned NUM_GATED = REF_IDX + 1;

  run_mode_e mode;
  logic      test_mode, hiz_mode;
  logic      cpu_src, pci_src;
  logic      sel48, strap_done;

  logic [NUM_GATED-1:0] src_live;
  logic [NUM_GATED-1:0] req_live;
  logic [NUM_GATED-1:0] en_live;
  logic [NUM_GATED-1:0] gated_raw;
  logic [NUM_GATED-1:0] gated_out;

  always_comb begin
    mode      = run_mode_e'(cfg_mode);
    test_mode = (mode == MODE_TEST);
    hiz_mode  = (mode == MODE_HIZ);
    cpu_src   = test_mode ? src_ref : src_cpu;
    pci_src   = test_mode ? src_ref : src_pci;
  end

  always_comb begin
    src_live = '0;
    req_live = '0;
    for (int i = 0; i < NUM_CPU; i++) begin
      src_live[i] = cpu_src;
      req_live[i] = cfg_en_cpu[i];
    end
    src_live[PCIF_IDX] = pci_src;
    req_live[PCIF_IDX] = cfg_en_pcif;
    for (int i = 0; i < NUM_PCI; i++) begin
      src_live[PCI_BASE+i] = pci_src;
      req_live[PCI_BASE+i] = cfg_en_pci[i];
    end
    src_live[APIC_IDX] = src_ref;
    req_live[APIC_IDX] = cfg_en_apic;
    // both stages of the shared pin take one combined run bit
    src_live[REF_IDX]  = src_ref;
    req_live[REF_IDX]  = cfg_en_ref[1] & cfg_en_ref[0];
  end

  for (genvar g = 0; g < NUM_GATED; g++) begin : g_gate
    clkctl_gate_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .src      (src_live[g]),
      .en_req   (req_live[g]),
      .gclk     (gated_raw[g]),
      .en_state (en_live[g])
    );
  end

  assign gated_out = hiz_mode ? '0 : gated_raw;

  clkctl_strap u_strap (
    .clk   (clk),
    .rst_n (rst_n),
    .strap (strap_sel48),
    .sel48 (sel48),
    .done  (strap_done)
  );

  clkctl_freq_sel u_fsel (
    .hw_fast  (hw_fast),
    .use_reg  (cfg_fsrc),
    .reg_code (cfg_fcode),
    .code     (fsel_code)
  );

  always_comb begin
    cpu_clk     = gated_out[NUM_CPU-1:0];
    pcif_clk    = gated_out[PCIF_IDX];
    pci_clk     = gated_out[PCI_BASE +: NUM_PCI];
    apic_clk    = gated_out[APIC_IDX];
    ref_clk_a   = gated_out[REF_IDX];
    ref_clk_b   = gated_out[REF_IDX];
    usb48_clk   = hiz_mode ? 1'b0 : src_48;
    mix_clk     = hiz_mode ? 1'b0 : (sel48 ? src_48 : src_24);
    pad_oe      = ~hiz_mode;
    spread_on   = (mode == MODE_SPREAD);
    spread_down = cfg_spread_down;
  end
endmodule

// File: rtl/clkctl_chk.sv
module clkctl_chk #(
  parameter int unsigned NUM_CPU = 2,
  parameter int unsigned NUM_PCI = 6,
  parameter int unsigned NUM_GATED = NUM_CPU + NUM_PCI + 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           cfg_mode,
  input logic                 cfg_fsrc,
  input logic                 hw_fast,
  input logic                 src_ref,
  input logic [NUM_CPU-1:0]   cpu_clk,
  input logic                 pcif_clk,
  input logic [NUM_PCI-1:0]   pci_clk,
  input logic                 apic_clk,
  input logic                 ref_clk_a,
  input logic                 ref_clk_b,
  input logic                 usb48_clk,
  input logic                 mix_clk,
  input logic                 pad_oe,
  input logic [2:0]           fsel_code,
  input logic                 spread_on,
  input logic [NUM_GATED-1:0] en_live,
  input logic [NUM_GATED-1:0] src_live,
  input logic                 strap_done,
  input logic                 strap_sel
);
  logic [NUM_GATED-1:0] gated_obs;
  assign gated_obs = {ref_clk_a, apic_clk, pci_clk, pcif_clk, cpu_clk};

  for (genvar g = 0; g < NUM_GATED; g++) begin : g_chk
    AST_SWITCH_WHEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (en_live[g] != $past(en_live[g])) |-> !$past(src_live[g])); // R2
    AST_STOPPED_IS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !en_live[g] |-> !gated_obs[g]); // R1
  end

  AST_REF_STAGES_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_clk_a == ref_clk_b); // R11
  AST_HIZ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'b11) |-> (!pad_oe && gated_obs == '0 && !usb48_clk && !mix_clk)); // R6
  AST_SPREAD_ONLY_MODE2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode != 2'b10) |-> !spread_on); // R5
  AST_TEST_FOLLOWS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'b01 && !src_ref) |-> (cpu_clk == '0 && !pcif_clk && pci_clk == '0)); // R4
  AST_PIN_CODE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_fsrc && !$past(cfg_fsrc) && $stable(hw_fast)) |-> $stable(fsel_code)); // R7
  AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strap_done) |-> $stable(strap_sel)); // R10
endmodule

bind clkctl_top clkctl_chk #(.NUM_CPU(NUM_CPU), .NUM_PCI(NUM_PCI)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_mode   (cfg_mode),
  .cfg_fsrc   (cfg_fsrc),
  .hw_fast    (hw_fast),
  .src_ref    (src_ref),
  .cpu_clk    (cpu_clk),
  .pcif_clk   (pcif_clk),
  .pci_clk    (pci_clk),
  .apic_clk   (apic_clk),
  .ref_clk_a  (ref_clk_a),
  .ref_clk_b  (ref_clk_b),
  .usb48_clk  (usb48_clk),
  .mix_clk    (mix_clk),
  .pad_oe     (pad_oe),
  .fsel_code  (fsel_code),
  .spread_on  (spread_on),
  .en_live    (en_live),
  .src_live   (src_live),
  .strap_done (strap_done),
  .strap_sel  (sel48)
);

// File: tb/test_clkctl_top.sv
module test_clkctl_top;
  localparam int NC = 2;
  localparam int NP = 6;
  localparam int NG = NC + NP + 3;

  logic clk = 1'b0;
  logic rst_n;
  logic strap_sel48, hw_fast, cfg_fsrc, cfg_spread_down, cfg_en_pcif, cfg_en_apic;
  logic [1:0] cfg_mode, cfg_en_ref;
  logic [2:0] cfg_fcode;
  logic [NC-1:0] cfg_en_cpu;
  logic [NP-1:0] cfg_en_pci;
  logic src_cpu, src_pci, src_ref, src_48, src_24;
  logic [NC-1:0] cpu_clk;
  logic [NP-1:0] pci_clk;
  logic pcif_clk, apic_clk, ref_clk_a, ref_clk_b, usb48_clk, mix_clk, pad_oe;
  logic spread_on, spread_down;
  logic [2:0] fsel_code;

  clkctl_top #(.NUM_CPU(NC), .NUM_PCI(NP)) i_clkctl_top (.*);

  always #4 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  int t = 0;
  bit finished = 0;
  bit en_m [NG];
  bit sel_m, done_m;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s at cycle %0d: got %0h expected %0h", tag, t, got, exp);
    end
  endtask

  function automatic bit src_of(int i);
    bit tst = (cfg_mode == 2'b01);
    if (i < NC + 1 + NP) begin
      if (tst) return src_ref;
      return (i < NC) ? src_cpu : src_pci;
    end
    return src_ref;
  endfunction

  function automatic bit req_of(int i);
    if (i < NC) return cfg_en_cpu[i];
    if (i == NC) return cfg_en_pcif;
    if (i < NC + 1 + NP) return cfg_en_pci[i-NC-1];
    if (i == NC + 1 + NP) return cfg_en_apic;
    return cfg_en_ref[0] & cfg_en_ref[1];
  endfunction

  // one control clock: model the edge just passed, move sources, compare
  task automatic step(string ph);
    logic [NG-1:0] exp_g;
    logic [NG-1:0] got_g;
    @(negedge clk);
    if (!rst_n) begin
      for (int i = 0; i < NG; i++) en_m[i] = 1'b1;
      sel_m = 1'b1; done_m = 1'b0;
    end else begin
      for (int i = 0; i < NG; i++) if (!src_of(i)) en_m[i] = req_of(i);
      if (!done_m) begin sel_m = strap_sel48; done_m = 1'b1; end
    end
    t++;
    src_cpu = t[0];
    src_pci = t[1];
    src_ref = (t % 3 == 0);
    src_48  = t[0] ^ t[2];
    src_24  = t[2];
    #1;
    for (int i = 0; i < NG; i++) exp_g[i] = (cfg_mode != 2'b11) && src_of(i) && en_m[i];
    got_g = {ref_clk_a, apic_clk, pci_clk, pcif_clk, cpu_clk};
    chk(ph, 32'(got_g), 32'(exp_g));
    chk("R11 ref stages", 32'(ref_clk_b), 32'(ref_clk_a));
    chk("R6 pad enable", 32'(pad_oe), 32'(cfg_mode != 2'b11));
    chk("R5 spread flag", 32'(spread_on), 32'(cfg_mode == 2'b10));
    chk("R9 spread shape", 32'(spread_down), 32'(cfg_spread_down));
    chk("R7/R8 freq code", 32'(fsel_code),
        32'(cfg_fsrc ? cfg_fcode : (hw_fast ? 3'b011 : 3'b001)));
    chk("R10 mix output", 32'(mix_clk),
        32'((cfg_mode == 2'b11) ? 1'b0 : (sel_m ? src_48 : src_24)));
    chk("R6 usb output", 32'(usb48_clk), 32'((cfg_mode != 2'b11) & src_48));
  endtask

  task automatic run(string ph, int n);
    for (int k = 0; k < n; k++) step(ph);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; strap_sel48 = 1'b0; hw_fast = 1'b1; cfg_mode = 2'b00;
    cfg_fsrc = 1'b0; cfg_fcode = 3'b000; cfg_spread_down = 1'b0;
    cfg_en_cpu = '0; cfg_en_pcif = 1'b0; cfg_en_pci = '0; cfg_en_apic = 1'b0;
    cfg_en_ref = 2'b00;
    src_cpu = 0; src_pci = 0; src_ref = 0; src_48 = 0; src_24 = 0;
    for (int i = 0; i < NG; i++) en_m[i] = 1'b1;
    sel_m = 1'b1; done_m = 1'b0;
    // R12: reset forces every run state on, mix carries 48 MHz
    run("R12 reset state", 4);
    @(negedge clk); rst_n = 1'b1;
    // R10: strap 0 captured at first edge, later change ignored
    run("R12 after release", 2);
    strap_sel48 = 1'b1;
    run("R10 strap held", 6);
    // R1/R2: run bits switch while sources toggle with different periods
    cfg_en_cpu = '1; cfg_en_pcif = 1'b1; cfg_en_pci = '1; cfg_en_apic = 1'b1;
    cfg_en_ref = 2'b11;
    run("R3 normal mode", 8);
    for (int p = 0; p < 12; p++) begin
      cfg_en_cpu = NC'(p * 3 + 1);
      cfg_en_pci = NP'(p * 11 + 5);
      cfg_en_pcif = p[0];
      cfg_en_apic = p[1];
      cfg_en_ref = 2'(p);
      run("R1 R2 gating", 1 + p % 3);
    end
    // R11: only both bits set lets the shared pin run
    cfg_en_ref = 2'b01; run("R11 ref pair", 5);
    cfg_en_ref = 2'b10; run("R11 ref pair", 5);
    cfg_en_ref = 2'b11; run("R11 ref pair", 5);
    // R4: test mode forwards the reference clock
    cfg_en_cpu = 2'b01; cfg_en_pci = 6'b101101; cfg_en_pcif = 1'b1;
    cfg_mode = 2'b01; run("R4 test mode", 10);
    cfg_en_cpu = 2'b11; run("R4 test mode", 6);
    // R5/R9: spread mode and shape passthrough
    cfg_mode = 2'b10; cfg_spread_down = 1'b1; run("R5 spread mode", 5);
    cfg_spread_down = 1'b0; run("R9 spread shape", 3);
    // R6: all outputs off
    cfg_mode = 2'b11; run("R6 tristate", 6);
    cfg_en_pci = '1; run("R6 tristate", 3);
    cfg_mode = 2'b00; run("R3 back to normal", 4);
    // R7/R8: frequency code source
    hw_fast = 1'b0; run("R7 pin slow", 3);
    hw_fast = 1'b1; run("R7 pin fast", 3);
    cfg_fsrc = 1'b1;
    for (int c = 0; c < 8; c++) begin
      cfg_fcode = 3'(c); hw_fast = c[0];
      run("R8 register code", 2);
    end
    // R10/R12: second reset captures strap 1
    @(negedge clk); rst_n = 1'b0;
    run("R12 reset again", 3);
    @(negedge clk); rst_n = 1'b1;
    run("R10 strap 48", 2);
    strap_sel48 = 1'b0;
    run("R10 strap held", 6);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule